// File: doc/BRIEF.md
# Four-Bit Successive-Approximation Conversion Sequencer

This block drives a 4-bit successive-approximation conversion that relies on an external reference DAC and an analog comparator. A start strobe latches a two-bit channel select. The block then enables the matching analog input switch and sets the DAC code to mid-scale. It then resolves the code one bit at a time, from the most significant bit down, by reading the comparator. The DAC output for code n is (n+1)/16 of the supply. A comparator reading of 1 therefore means the selected input is above that level.

The analog parts need time to settle after every change of the DAC code. The block waits a fixed number of clock cycles, set by a parameter, before it samples the comparator. With a 10 MHz clock, the default of 90 cycles covers the 6 to 9 µs the comparison takes. When the conversion ends, a one-cycle done pulse marks the result as valid. A select code that names no channel ends the request at once, returns a zero result and raises an error flag.

Top module: `sar4_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, err, result, dac_code and chan_en are all zero.
- R2: While busy, chan_en is one-hot: select 0 drives bit 0, select 1 drives bit 1 and select 2 drives bit 2. While idle, chan_en is all zero.
- R3: In the first busy cycle after a start, dac_code is 4'b1000.
- R4: At each decision, the bit under trial is kept when cmp_in is 1 and cleared when cmp_in is 0. The next lower bit is then set as the new trial. The final result is the largest code n whose comparator reading was 1, or 0 if there is none.
- R5: The comparator is sampled only after dac_code has been stable for SETTLE_CYCLES cycles. Busy stays high for exactly 4*SETTLE_CYCLES cycles.
- R6: Done is high for exactly one cycle, in the first cycle after busy falls. Result is valid in that cycle and holds until the next completion.
- R7: A start with select 2'b11 raises done and err in the next cycle with result 0000. Busy never rises for that request.
- R8: A start that arrives while busy has no effect on the channel, the duration or the result of the conversion in progress.
- R9: The err flag is cleared when a conversion on a valid channel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only while idle |
| chan_sel | input | 2 | Channel select; 2'b11 is reserved |
| cmp_in | input | 1 | Comparator result, 1 = input above reference |
| dac_code | output | 4 | Code driven to the reference DAC |
| chan_en | output | 3 | One-hot analog switch enables |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request named the reserved channel |
| result | output | 4 | Converted code |

## Verification
Every channel is swept through input levels from 0 to 33 thirty-seconds of the supply. This places each level either exactly on a reference threshold or halfway between two thresholds, which separates a kept bit from a cleared bit at every weight. It also shows whether the two ends of the scale resolve correctly. The comparator model gives the inverted answer until the code has been stable for the settle time, so a sample taken one cycle early yields a wrong result. Separate runs check the reserved select, a start issued during a conversion, and the clearing of err.

// File: rtl/sar4_pkg.sv
package sar4_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_t;
endpackage

// File: rtl/sar4_chan_decode.sv
module sar4_chan_decode #(
  parameter int NCHAN = 3,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  output logic [NCHAN-1:0] onehot,
  output logic             reserved
);
  for (genvar i = 0; i < NCHAN; i++) begin : g_dec
    assign onehot[i] = (sel == SEL_W'(i));
  end
  assign reserved = (32'(sel) >= NCHAN);
endmodule

// File: rtl/sar4_settle_timer.sv
module sar4_settle_timer #(
  parameter int SETTLE_CYCLES = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the settle count never passes its programmed limit
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < SETTLE_CYCLES);
  // R5: after a load the timer restarts from zero, so no sample comes early
  a_r5_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/sar4_trial_reg.sv
module sar4_trial_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             cmp,
  output logic [WIDTH-1:0] code_q,
  output logic [WIDTH-1:0] code_nx,
  output logic             last
);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] mask_q, mask_d, code_d, settled;

  assign settled = (code_q & ~mask_q) | (cmp ? mask_q : '0);
  assign code_nx = settled | (mask_q >> 1);
  assign last    = mask_q[0];

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    if (load) begin
      code_d = TOP;
      mask_d = TOP;
    end else if (step) begin
      code_d = code_nx;
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  // R3: a conversion opens at mid-scale
  a_r3_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (code_q == TOP));
  // R4: at most one bit is under trial
  a_r4_mask_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
  // R4: after a non-final decision the next lower bit is set as the trial
  a_r4_next_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !load) |=> ((code_q & mask_q) == mask_q) && $countones(mask_q) == 1);
endmodule

// File: rtl/sar4_ctrl.sv
module sar4_ctrl #(
  parameter int WIDTH         = 4,
  parameter int NCHAN         = 3,
  parameter int SEL_W         = 2,
  parameter int SETTLE_CYCLES = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] chan_sel,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] dac_code,
  output logic [NCHAN-1:0] chan_en,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [WIDTH-1:0] result
);
  import sar4_pkg::*;

  sar_state_t       state_q, state_d;
  logic [NCHAN-1:0] chan_q, chan_d, dec_onehot;
  logic             dec_rsvd;
  logic             done_q, done_d, err_q, err_d;
  logic [WIDTH-1:0] res_q, res_d, code_q, code_nx;
  logic             accept, load, tick, last, run;

  sar4_chan_decode #(.NCHAN(NCHAN), .SEL_W(SEL_W)) u_dec (
    .sel(chan_sel), .onehot(dec_onehot), .reserved(dec_rsvd));

  assign run    = (state_q == ST_CONV);
  assign accept = start && (state_q == ST_IDLE);
  assign load   = accept && !dec_rsvd;

  sar4_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(load), .run(run), .tick(tick));

  sar4_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst_n(rst_n), .load(load), .step(tick), .cmp(cmp_in),
    .code_q(code_q), .code_nx(code_nx), .last(last));

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    done_d  = 1'b0;
    err_d   = err_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dec_rsvd) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            res_d  = '0;
          end else begin
            state_d = ST_CONV;
            chan_d  = dec_onehot;
            err_d   = 1'b0;
          end
        end
      end
      ST_CONV: begin
        if (tick && last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = code_nx;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      done_q  <= done_d;
      err_q   <= err_d;
      res_q   <= res_d;
    end
  end

  assign busy     = run;
  assign chan_en  = run ? chan_q : '0;
  assign dac_code = code_q;
  assign done     = done_q;
  assign err      = err_q;
  assign result   = res_q;

  // R2: exactly one switch closed while converting, none while idle
  a_r2_enable_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(chan_en));
  a_r2_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (chan_en == '0));
  // R6: completion is flagged as busy drops
  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: a reserved request reports zero
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0));
  // R8: a start during a conversion leaves the selected channel alone
  a_r8_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!busy || $stable(chan_en)));
endmodule

// File: tb/sar4_ctrl_bench.sv
module sar4_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;

  logic       clk = 1'b0;
  logic       rst_n, start, cmp_in;
  logic [1:0] chan_sel;
  logic [3:0] dac_code, result;
  logic [2:0] chan_en;
  logic       busy, done, err;

  int checks = 0;
  int errors = 0;
  int vin [3];
  int sc = 0;
  logic [6:0] prev_obs = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar4_ctrl #(.SETTLE_CYCLES(SETTLE)) u_sar4_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_en(chan_en), .busy(busy),
    .done(done), .err(err), .result(result));

  // comparator model: gives the wrong answer until the code has settled
  always @(negedge clk) begin
    int ch;
    logic truth;
    if ({dac_code, chan_en} != prev_obs) sc = 0;
    else sc = sc + 1;
    prev_obs = {dac_code, chan_en};
    ch = chan_en[2] ? 2 : (chan_en[1] ? 1 : 0);
    truth = (vin[ch] > 2 * (int'(dac_code) + 1));
    if (chan_en == 3'b000) cmp_in = 1'b0;
    else cmp_in = (sc >= SETTLE - 1) ? truth : ~truth;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v);
    int e = 0;
    for (int n = 1; n < 16; n++) if (v > 2 * n + 2) e++;
    return e;
  endfunction

  // runs one conversion; optionally fires extra starts while busy
  task automatic do_conv(input int ch, input bit poke);
    int cnt = 0;
    int exp = expect_code(vin[ch]);
    chan_sel = 2'(ch);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 first trial code", int'(dac_code), 8);
    chk("R2 channel enable", int'(chan_en), 1 << ch);
    chk("R9 err cleared on accept", int'(err), 0);
    while (busy && cnt < 200) begin
      if (done) chk("R6 no done while busy", 1, 0);
      if (poke && cnt == 2) begin
        chan_sel = 2'((ch + 1) % 3);
        start = 1'b1;
      end else if (poke && cnt == 5) begin
        chan_sel = 2'b11;
        start = 1'b1;
      end else start = 1'b0;
      if (poke) chk("R8 channel held", int'(chan_en), 1 << ch);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R5 busy length", cnt, 4 * SETTLE);
    chk("R6 done pulse", int'(done), 1);
    chk("R4 result", int'(result), exp);
    chk("R2 idle enables", int'(chan_en), 0);
    if (poke) chk("R8 err untouched", int'(err), 0);
    @(negedge clk);
    chk("R6 done single cycle", int'(done), 0);
    chk("R6 result held", int'(result), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; chan_sel = 2'b00;
    vin[0] = 0; vin[1] = 0; vin[2] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 err in reset", int'(err), 0);
    chk("R1 result in reset", int'(result), 0);
    chk("R1 dac in reset", int'(dac_code), 0);
    chk("R1 enables in reset", int'(chan_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'({busy, done, err}), 0);

    for (int ch = 0; ch < 3; ch++) begin
      for (int v = 0; v <= 33; v++) begin
        vin[0] = 33 - v; vin[1] = (v * 7) % 34; vin[2] = (v + 17) % 34;
        vin[ch] = v;
        do_conv(ch, 1'b0);
      end
    end

    // R7: reserved channel
    chan_sel = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done", int'(done), 1);
    chk("R7 err", int'(err), 1);
    chk("R7 result zero", int'(result), 0);
    chk("R7 no busy", int'(busy), 0);
    chk("R7 no enable", int'(chan_en), 0);
    @(negedge clk);
    chk("R7 done single", int'(done), 0);
    chk("R7 err held", int'(err), 1);
    chk("R7 still idle", int'(busy), 0);

    // R9 and R8: valid conversion after error, with starts while busy
    vin[0] = 20; vin[1] = 5; vin[2] = 30;
    do_conv(0, 1'b1);
    vin[1] = 33;
    do_conv(1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule